// File: doc/BRIEF.md
# Multi-Width Serial Memory Slave Engine

This block is the slave-side protocol engine for a serial byte-addressed SRAM. It watches an active-low select and a serial clock, and has four bidirectional data lanes, split into input, output and output-enable vectors. It decodes a one-byte opcode and collects a 24-bit address field. For reads it inserts turnaround clocks when the bus is wide, then streams bytes out of or into a simple byte-wide storage port. The lane width can be one, two or four bits. It is chosen at run time by command and is kept across transactions.

The block samples the serial clock and select with a fast system clock, and it acts on the detected serial-clock edges. Inputs are captured at a detected rising edge. Outputs are updated at a detected falling edge. The policy for moving to the next byte address (page wrap, linear burst) belongs to a neighbouring block. After each byte this engine takes that block's proposal from `adv_addr`, and it exposes `mode_reg` and `lane_mode` so neighbours can pick their policy. Pausing the bus is also handled outside this block.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset, `lane_mode` is 0, `mode_reg` is 40h, every `sio_oe` bit is 0 and `mem_we` is 0.
- R2: Raising `cs_n` aborts any transfer. A byte that is only partly shifted in is never written. `sio_oe` is all zero from the second system clock with `cs_n` high. The next low period of `cs_n` starts with a fresh opcode.
- R3: The opcode is shifted in MSB first at the current width. It takes 8 serial clocks at width 1, 4 at width 2 and 2 at width 4.
- R4: The `lane_mode` encoding is 0 for one lane, 1 for two lanes and 2 for four lanes. Opcode 38h selects 2, 3Bh selects 1 and FFh selects 0. The setting changes only while `cs_n` is low and persists across transactions.
- R5: READ (03h) and WRITE (02h) take a 24-bit address MSB first. Only its low 17 bits reach `mem_addr`.
- R6: In one-lane mode, read data starts on the falling edge right after the last address bit, with no turnaround. Only lane 1 is driven, and `sio_oe` is 0010b.
- R7: In two-lane mode a read has 4 turnaround clocks and then drives lanes 1:0 (`sio_oe` 0011b, lane 1 carries the higher bit). In four-lane mode a read has 2 turnaround clocks and then drives all lanes (`sio_oe` 1111b, lane 3 highest). During turnaround `sio_oe` is 0.
- R8: Each time a read byte is loaded for output, `mem_addr` takes `adv_addr`, so consecutive bytes follow the neighbour's address sequence.
- R9: Each completed write byte gives one single-cycle `mem_we` pulse, with the byte on `mem_wdata` at the current `mem_addr`. The next cycle `mem_addr` takes `adv_addr`.
- R10: Opcode 05h drives `mode_reg` from the falling edge after the opcode. The byte repeats for as long as clocks continue.
- R11: Opcode 01h loads the next byte into `mode_reg`. Later bytes in the same transaction are ignored. `mode_reg` never changes while `cs_n` is high.
- R12: Any other opcode leaves `sio_oe` at 0, issues no write, and changes neither `mode_reg` nor `lane_mode` until `cs_n` rises.
- R13: `sio_out` changes only in the system cycle after a detected serial-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, synchronous to clk |
| sck | input | 1 | Serial clock, synchronous to clk |
| sio_in | input | 4 | Input value of the four data lanes |
| sio_out | output | 4 | Output value of the four data lanes |
| sio_oe | output | 4 | Per-lane output enable |
| lane_mode | output | 2 | Current width: 0 one lane, 1 two, 2 four |
| mode_reg | output | 8 | Mode byte for neighbouring blocks |
| mem_addr | output | 17 | Storage byte address |
| adv_addr | input | 17 | Next address proposed by the advance block |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Byte at mem_addr |

## Verification
Some properties are checked on every cycle: the lane drivers are off while deselected, the output lanes move only after a falling edge, the write strobe is a single cycle, width and mode byte are frozen while deselected, and the enable vector takes one of the four legal shapes. The turnaround count at each width, the lane bit order, the address truncation and the advance sequence can only be seen in the bench's transactions. The same holds for mode-byte readback, ignored opcodes and aborted transfers. The bench checks these against its own memory model, using write and read transactions at every width with random addresses and data.

// File: rtl/sms_pkg.sv
package sms_pkg;
   typedef enum logic [1:0] {
      LW_1 = 2'd0,
      LW_2 = 2'd1,
      LW_4 = 2'd2
   } lane_w_e;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_DUMMY,
      PH_RD,
      PH_WR,
      PH_MR_RD,
      PH_MR_WR,
      PH_SKIP
   } phase_e;

   localparam logic [7:0] OPC_RD     = 8'h03;
   localparam logic [7:0] OPC_WR     = 8'h02;
   localparam logic [7:0] OPC_QUAD   = 8'h38;
   localparam logic [7:0] OPC_DUAL   = 8'h3B;
   localparam logic [7:0] OPC_SINGLE = 8'hFF;
   localparam logic [7:0] OPC_MR_RD  = 8'h05;
   localparam logic [7:0] OPC_MR_WR  = 8'h01;
endpackage

// File: rtl/sms_sck_edges.sv
module sms_sck_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   output logic rise,
   output logic fall
);
   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck;
   end

   assign rise = !cs_n &&  sck && !sck_q;
   assign fall = !cs_n && !sck &&  sck_q;
endmodule

// File: rtl/sms_rx_deser.sv
module sms_rx_deser import sms_pkg::*; #(
   parameter int SR_W  = 17,
   parameter int LANES = 4,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             restart,
   input  lane_w_e          width,
   input  logic [LANES-1:0] lanes_in,
   output logic [SR_W-1:0]  nxt_sr,
   output logic [CNT_W-1:0] nxt_cnt
);
   logic [SR_W-1:0]  sr;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] stp;

   always_comb begin
      case (width)
         LW_2:    begin nxt_sr = {sr[SR_W-3:0], lanes_in[1:0]}; stp = CNT_W'(2); end
         LW_4:    begin nxt_sr = {sr[SR_W-5:0], lanes_in[3:0]}; stp = CNT_W'(4); end
         default: begin nxt_sr = {sr[SR_W-2:0], lanes_in[0]};   stp = CNT_W'(1); end
      endcase
      nxt_cnt = cnt + stp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (shift) begin
         sr  <= nxt_sr;
         cnt <= restart ? '0 : nxt_cnt;
      end
   end
endmodule

// File: rtl/sms_tx_ser.sv
module sms_tx_ser import sms_pkg::*; #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_en,
   input  lane_w_e           width,
   input  logic [BYTE_W-1:0] src,
   output logic              load,
   output logic [LANES-1:0]  lanes_out,
   output logic [LANES-1:0]  lanes_oe
);
   localparam int BP_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] osr;
   logic [BYTE_W-1:0] nxt_byte;
   logic [BP_W-1:0]   bitpos;
   logic [BP_W-1:0]   step_bp;
   logic [LANES-1:0]  lane_d;
   logic [LANES-1:0]  lane_e;

   always_comb begin
      case (width)
         LW_2:    step_bp = BP_W'(2);
         LW_4:    step_bp = BP_W'(4);
         default: step_bp = BP_W'(1);
      endcase
   end

   assign load     = step_en && (bitpos == '0);
   assign nxt_byte = (bitpos == '0) ? src : (osr << step_bp);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic d;
      logic e;
      if (i < 2) begin : g_low
         always_comb begin
            case (width)
               LW_4:    begin d = nxt_byte[BYTE_W-4+i]; e = 1'b1; end
               LW_2:    begin d = nxt_byte[BYTE_W-2+i]; e = 1'b1; end
               default: begin
                  d = (i == 1) ? nxt_byte[BYTE_W-1] : 1'b0;
                  e = (i == 1);
               end
            endcase
         end
      end else begin : g_high
         always_comb begin
            d = (width == LW_4) ? nxt_byte[BYTE_W-4+i] : 1'b0;
            e = (width == LW_4);
         end
      end
      assign lane_d[i] = d;
      assign lane_e[i] = e;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr       <= '0;
         bitpos    <= '0;
         lanes_out <= '0;
         lanes_oe  <= '0;
      end else if (clr) begin
         bitpos   <= '0;
         lanes_oe <= '0;
      end else if (step_en) begin
         osr       <= nxt_byte;
         bitpos    <= bitpos + step_bp;
         lanes_out <= lane_d;
         lanes_oe  <= lane_e;
      end
   end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave import sms_pkg::*; #(
   parameter int         ADDR_W       = 17,
   parameter int         ADDR_FIELD_W = 24,
   parameter int         BYTE_W       = 8,
   parameter int         LANES        = 4,
   parameter int         DUMMY_DUAL   = 4,
   parameter int         DUMMY_QUAD   = 2,
   parameter logic [7:0] MODE_RST     = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic [LANES-1:0]  sio_in,
   output logic [LANES-1:0]  sio_out,
   output logic [LANES-1:0]  sio_oe,
   output logic [1:0]        lane_mode,
   output logic [BYTE_W-1:0] mode_reg,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [ADDR_W-1:0] adv_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [BYTE_W-1:0] mem_rdata
);
   localparam int CNT_W = $clog2(ADDR_FIELD_W + LANES + 1);
   localparam int DMAX  = (DUMMY_DUAL > DUMMY_QUAD) ? DUMMY_DUAL : DUMMY_QUAD;
   localparam int DC_W  = (DMAX < 2) ? 1 : $clog2(DMAX);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("BYTE_W must be 8");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("LANES must be 4");
   end
   if (ADDR_W < BYTE_W || ADDR_W > ADDR_FIELD_W) begin : g_bad_addr
      $error("ADDR_W must lie between BYTE_W and ADDR_FIELD_W");
   end

   phase_e           phase_q;
   lane_w_e          width_q;
   logic [DC_W-1:0]  dcnt;
   logic [DC_W:0]    dummy_need;
   logic             is_read;
   logic [BYTE_W-1:0] mode_q;
   logic             rise, fall;
   logic [ADDR_W-1:0] rx_nxt;
   logic [CNT_W-1:0] rx_cnt;
   logic [CNT_W-1:0] target;
   logic             field_done;
   logic             tx_step, tx_load;
   logic [BYTE_W-1:0] tx_src;

   sms_sck_edges u_edges (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
      .rise(rise), .fall(fall)
   );

   assign target     = (phase_q == PH_ADDR) ? CNT_W'(ADDR_FIELD_W) : CNT_W'(BYTE_W);
   assign field_done = (rx_cnt == target);

   sms_rx_deser #(.SR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(cs_n), .shift(rise), .restart(field_done),
      .width(width_q), .lanes_in(sio_in), .nxt_sr(rx_nxt), .nxt_cnt(rx_cnt)
   );

   assign tx_step = fall && (phase_q == PH_RD || phase_q == PH_MR_RD);
   assign tx_src  = (phase_q == PH_MR_RD) ? mode_q : mem_rdata;

   sms_tx_ser #(.BYTE_W(BYTE_W), .LANES(LANES)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(cs_n), .step_en(tx_step), .width(width_q),
      .src(tx_src), .load(tx_load), .lanes_out(sio_out), .lanes_oe(sio_oe)
   );

   always_comb begin
      case (width_q)
         LW_2:    dummy_need = (DC_W+1)'(DUMMY_DUAL);
         LW_4:    dummy_need = (DC_W+1)'(DUMMY_QUAD);
         default: dummy_need = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_CMD;
         width_q   <= LW_1;
         dcnt      <= '0;
         is_read   <= 1'b0;
         mode_q    <= MODE_RST;
         mem_addr  <= '0;
         mem_wdata <= '0;
         mem_we    <= 1'b0;
      end else begin
         mem_we <= 1'b0;
         if (mem_we) mem_addr <= adv_addr;
         if (cs_n) begin
            phase_q <= PH_CMD;
            dcnt    <= '0;
         end else if (rise) begin
            case (phase_q)
               PH_CMD: if (field_done) begin
                  case (rx_nxt[BYTE_W-1:0])
                     OPC_RD:     begin phase_q <= PH_ADDR; is_read <= 1'b1; end
                     OPC_WR:     begin phase_q <= PH_ADDR; is_read <= 1'b0; end
                     OPC_QUAD:   begin phase_q <= PH_SKIP; width_q <= LW_4; end
                     OPC_DUAL:   begin phase_q <= PH_SKIP; width_q <= LW_2; end
                     OPC_SINGLE: begin phase_q <= PH_SKIP; width_q <= LW_1; end
                     OPC_MR_RD:  phase_q <= PH_MR_RD;
                     OPC_MR_WR:  phase_q <= PH_MR_WR;
                     default:    phase_q <= PH_SKIP;
                  endcase
               end
               PH_ADDR: if (field_done) begin
                  mem_addr <= rx_nxt;
                  dcnt     <= '0;
                  if (!is_read)                phase_q <= PH_WR;
                  else if (dummy_need == '0)   phase_q <= PH_RD;
                  else                         phase_q <= PH_DUMMY;
               end
               PH_DUMMY: begin
                  if ({1'b0, dcnt} == dummy_need - 1'b1) phase_q <= PH_RD;
                  else                                   dcnt    <= dcnt + 1'b1;
               end
               PH_WR: if (field_done) begin
                  mem_we    <= 1'b1;
                  mem_wdata <= rx_nxt[BYTE_W-1:0];
               end
               PH_MR_WR: if (field_done) begin
                  mode_q  <= rx_nxt[BYTE_W-1:0];
                  phase_q <= PH_SKIP;
               end
               default: ;
            endcase
         end else if (tx_load && phase_q == PH_RD) begin
            mem_addr <= adv_addr;
         end
      end
   end

   assign lane_mode = width_q;
   assign mode_reg  = mode_q;
endmodule

// File: rtl/sms_chk.sv
module sms_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sck,
   input logic [3:0] sio_out,
   input logic [3:0] sio_oe,
   input logic [1:0] lane_mode,
   input logic [7:0] mode_reg,
   input logic       mem_we
);
   logic s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1 <= 1'b0;
      else        s1 <= sck;
   end

   // R2
   cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> (sio_oe == 4'b0000));

   // R13
   out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(s1 && !sck) |-> $stable(sio_out));

   // R9
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R4
   lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> $stable(lane_mode));

   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> $stable(mode_reg));

   // R7
   oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sio_oe == 4'b0000) || (sio_oe == 4'b0010) || (sio_oe == 4'b0011) || (sio_oe == 4'b1111));
endmodule

bind serial_mem_slave sms_chk u_sms_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
   .sio_out(sio_out), .sio_oe(sio_oe), .lane_mode(lane_mode),
   .mode_reg(mode_reg), .mem_we(mem_we)
);

// File: tb/serial_mem_slave_bench.sv
module serial_mem_slave_bench;
   logic        clk = 1'b0;
   logic        rst_n, cs_n, sck;
   logic [3:0]  sio_in, sio_out, sio_oe;
   logic [1:0]  lane_mode;
   logic [7:0]  mode_reg, mem_wdata, mem_rdata;
   logic [16:0] mem_addr, adv_addr;
   logic        mem_we;

   logic [7:0]  mem [256];
   logic [7:0]  ref_mem [256];
   logic [16:0] log_a [64];
   logic [7:0]  log_d [64];
   int          we_cnt = 0;
   int          n_chk = 0, n_fail = 0;
   int          cur_w = 0;
   logic [3:0]  last_dout, last_oe, hi_out;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   serial_mem_slave u_serial_mem_slave (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
      .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe),
      .lane_mode(lane_mode), .mode_reg(mode_reg),
      .mem_addr(mem_addr), .adv_addr(adv_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   assign adv_addr  = mem_addr + 17'd1;

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         log_a[we_cnt % 64] <= mem_addr;
         log_d[we_cnt % 64] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] oe_pat(input int w);
      case (w)
         0:       return 4'b0010;
         1:       return 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic int dummies(input int w);
      case (w)
         0:       return 0;
         1:       return 4;
         default: return 2;
      endcase
   endfunction

   function automatic logic [3:0] chunk_of(input logic [7:0] b, input int w, input int u);
      logic [7:0] t;
      t = b >> (8 - (u + 1) * (1 << w));
      case (w)
         0:       return {3'b000, t[0]};
         1:       return {2'b00, t[1:0]};
         default: return t[3:0];
      endcase
   endfunction

   function automatic logic [7:0] take(input logic [7:0] acc, input logic [3:0] d, input int w);
      case (w)
         0:       return {acc[6:0], d[1]};
         1:       return {acc[5:0], d[1:0]};
         default: return {acc[3:0], d[3:0]};
      endcase
   endfunction

   task automatic unit(input logic [3:0] din);
      sio_in = din;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      hi_out = sio_out;
      @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
      last_dout = sio_out;
      last_oe   = sio_oe;
   endtask

   task automatic send_byte(input logic [7:0] b, input int w);
      for (int u = 0; u < (8 >> w); u++) unit(chunk_of(b, w, u));
   endtask

   task automatic recv_byte(input int w, output logic [7:0] b);
      logic [3:0] prev;
      b = 8'h00;
      chk("R6 lane enables during data", 32'(last_oe), 32'(oe_pat(w)));
      for (int u = 0; u < (8 >> w); u++) begin
         b    = take(b, last_dout, w);
         prev = last_dout;
         unit(4'h0);
         chk("R13 lanes held across rising edge", 32'(hi_out), 32'(prev));
      end
   endtask

   task automatic sel;
      @(negedge clk); cs_n = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic desel;
      @(negedge clk); cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_addr(input logic [23:0] a);
      send_byte(a[23:16], cur_w);
      send_byte(a[15:8], cur_w);
      send_byte(a[7:0], cur_w);
   endtask

   task automatic do_write(input logic [23:0] a, input int n);
      int         base;
      logic [7:0] dat [4];
      logic [16:0] ad;
      base = we_cnt;
      sel();
      send_byte(8'h02, cur_w);
      send_addr(a);
      for (int i = 0; i < n; i++) begin
         dat[i] = 8'($urandom);
         send_byte(dat[i], cur_w);
      end
      desel();
      chk("R9 one strobe per byte", 32'(we_cnt - base), 32'(n));
      for (int i = 0; i < n; i++) begin
         ad = a[16:0] + 17'(i);
         chk("R5 write address low 17 bits", 32'(log_a[(base + i) % 64]), 32'(ad));
         chk("R9 write data", 32'(log_d[(base + i) % 64]), 32'(dat[i]));
         ref_mem[ad[7:0]] = dat[i];
      end
   endtask

   task automatic do_read(input logic [23:0] a, input int n);
      logic [7:0]  b;
      logic [16:0] ad;
      sel();
      send_byte(8'h03, cur_w);
      send_addr(a);
      if (dummies(cur_w) > 0) begin
         chk("R7 no drive before turnaround", 32'(last_oe), 32'h0);
         for (int k = 0; k < dummies(cur_w); k++) begin
            if (k == dummies(cur_w) - 1)
               chk("R7 no drive during turnaround", 32'(last_oe), 32'h0);
            unit(4'h0);
         end
      end
      chk("R7 drive starts after turnaround", 32'(last_oe), 32'(oe_pat(cur_w)));
      for (int i = 0; i < n; i++) begin
         ad = a[16:0] + 17'(i);
         recv_byte(cur_w, b);
         chk("R8 sequential read data", 32'(b), 32'(ref_mem[ad[7:0]]));
      end
      desel();
      chk("R2 lanes released", 32'(sio_oe), 32'h0);
   endtask

   task automatic do_rdmr(input logic [7:0] exp);
      logic [7:0] b;
      sel();
      send_byte(8'h05, cur_w);
      chk("R3 opcode length then drive", 32'(last_oe), 32'(oe_pat(cur_w)));
      recv_byte(cur_w, b);
      chk("R10 mode byte", 32'(b), 32'(exp));
      recv_byte(cur_w, b);
      chk("R10 mode byte repeats", 32'(b), 32'(exp));
      desel();
   endtask

   task automatic do_wrmr(input logic [7:0] v);
      sel();
      send_byte(8'h01, cur_w);
      send_byte(v, cur_w);
      send_byte(~v, cur_w);
      desel();
      chk("R11 mode byte written, later ignored", 32'(mode_reg), 32'(v));
   endtask

   task automatic set_width(input logic [7:0] op, input int nw);
      sel();
      send_byte(op, cur_w);
      desel();
      cur_w = nw;
      chk("R4 lane_mode after command", 32'(lane_mode), 32'(nw));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      logic [7:0] mr;
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 8'((i * 37 + 11) % 256);
         ref_mem[i] = 8'((i * 37 + 11) % 256);
      end
      rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sio_in = 4'h0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      chk("R1 lane_mode", 32'(lane_mode), 32'h0);
      chk("R1 mode_reg", 32'(mode_reg), 32'h40);
      chk("R1 sio_oe", 32'(sio_oe), 32'h0);
      chk("R1 mem_we", 32'(mem_we), 32'h0);

      do_rdmr(8'h40);
      do_write(24'hAB1FFE, 4);
      do_read(24'h551FFE, 4);
      do_wrmr(8'hC1);
      do_rdmr(8'hC1);
      do_wrmr(8'h40);

      // R2: abort a read mid-byte, then abort a write mid-byte
      sel();
      send_byte(8'h03, cur_w);
      send_addr(24'h000010);
      unit(4'h0);
      desel();
      chk("R2 read abort releases lanes", 32'(sio_oe), 32'h0);
      base = we_cnt;
      sel();
      send_byte(8'h02, cur_w);
      send_addr(24'h000020);
      for (int u = 0; u < 5; u++) unit(4'h1);
      desel();
      chk("R2 partial byte not written", 32'(we_cnt - base), 32'h0);
      do_rdmr(8'h40);

      set_width(8'h3B, 1);
      do_write(24'h012345, 3);
      do_read(24'h012345, 3);
      do_rdmr(8'h40);
      chk("R4 two-lane mode persists", 32'(lane_mode), 32'h1);

      set_width(8'h38, 2);
      do_write(24'hFF0100, 4);
      do_read(24'h000100, 4);
      do_rdmr(8'h40);

      // R12: unknown opcode
      base = we_cnt;
      mr   = mode_reg;
      sel();
      send_byte(8'hA5, cur_w);
      chk("R12 no drive after unknown opcode", 32'(last_oe), 32'h0);
      for (int k = 0; k < 3; k++) begin
         send_byte(8'($urandom), cur_w);
         chk("R12 still no drive", 32'(last_oe), 32'h0);
      end
      desel();
      chk("R12 no write", 32'(we_cnt - base), 32'h0);
      chk("R12 mode byte unchanged", 32'(mode_reg), 32'(mr));
      chk("R12 width unchanged", 32'(lane_mode), 32'h2);

      set_width(8'hFF, 0);
      do_read(24'h000100, 2);

      for (int it = 0; it < 10; it++) begin
         int nw;
         int n;
         logic [23:0] a;
         nw = int'($urandom % 3);
         if (nw != cur_w) begin
            if (cur_w != 0) set_width(8'hFF, 0);
            if (nw == 1) set_width(8'h3B, 1);
            if (nw == 2) set_width(8'h38, 2);
         end
         a = 24'($urandom);
         n = 1 + int'($urandom % 4);
         do_write(a, n);
         do_read(a, n);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule